// File: doc/BRIEF.md
# Auto-Acknowledging Prioritized Interrupt Controller

This block gathers a parameterized set of level-sensitive hardware interrupt lines and presents them to a small group of CPUs over a simple 32-bit register bus. Each line can be masked, can be forced pending by a software trigger bit that is ORed with its hardware input, and carries a routing word that names the CPUs it may be delivered to. Every CPU has its own interrupt output, which stays high while any unmasked, pending line is routed to it.

A CPU services interrupts by reading one event register, with its own index on the bus CPU-id input. The read returns a packed word naming the most urgent deliverable line, where the lowest line number is the most urgent. The same clock edge masks that line, so it cannot be reported again until software unmasks it. When nothing is deliverable the read returns zero and changes nothing. Mask and trigger state are changed through separate set and clear banks. In those banks a 1 bit acts and a 0 bit leaves its line untouched.

Register map, byte offsets: line-count word at 0x0004; event word at 0x2004; routing word for line n at 0x3000 + 4*n; trigger-set bank at 0x4000, trigger-clear bank at 0x4080, mask-set bank at 0x4100, mask-clear bank at 0x4180, raw hardware-level bank at 0x4200. Any other address reads as zero and ignores writes.

Top module: `aic_irq_ctrl`

## Requirements
- R1: A synchronous active-high reset sets every mask bit, clears every trigger bit and loads every routing word with 1 (CPU 0 only). After reset all CPU interrupt outputs are low and an event read returns 0.
- R2: In the mask-set (0x4100) and mask-clear (0x4180) banks, line n sits in the word at byte offset 4*(n>>5) and at bit n&31. A 1 sets or clears that mask bit and a 0 leaves it unchanged. Reading either bank returns the current mask bits.
- R3: The trigger-set (0x4000) and trigger-clear (0x4080) banks use the same layout and write-1 rule, and reading either returns the trigger bits. A line is pending when its hardware input is high or its trigger bit is set. The hardware bank (0x4200) reads the raw inputs and ignores writes.
- R4: When several deliverable lines are pending for a CPU, the event read reports the one with the lowest number.
- R5: The event read data arrives one cycle after the request, with bus_rvalid high. A non-zero event word holds 0 in bits [31:24], the value 1 in bits [23:16] and the line number in bits [15:0].
- R6: An event read for a CPU with no deliverable line returns 0 and leaves the mask unchanged.
- R7: A non-zero event read sets the mask bit of the reported line on the same clock edge that captures the read data. The line is not reported again until it is unmasked.
- R8: The routing word of line n (0x3000 + 4*n) holds one bit per CPU in bits [NUM_CPUS-1:0]. Reads return it zero-extended. The line is delivered, and reported by event reads, only to CPUs whose bit is set. The event read uses the bus CPU-id input to pick the CPU.
- R9: irq_out[c] is high exactly when some line is pending, unmasked and has routing bit c set.
- R10: The word at 0x0004 returns NUM_LINES in bits [15:0] and zero above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_irq | input | NUM_LINES | Level-sensitive hardware interrupt inputs |
| bus_req | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_cpu | input | CPU_W | Index of the CPU issuing the access |
| bus_rdata | output | 32 | Read data, valid while bus_rvalid is high |
| bus_rvalid | output | 1 | High in the cycle after a read request |
| irq_out | output | NUM_CPUS | Interrupt request per CPU |

## Verification
The sharp case is an event read that lands in the same cycle as a hardware input rising on a line numbered below the line that was already waiting. The bench drives the new level and the read request in the same half-cycle. The read must report the lower line and mask only that line. The interrupt output must stay high for the older line, and the next read must return the older line. Beyond this directed case, randomly interleaved input changes, bank writes, routing writes and event reads from random CPUs are compared against a bench model after every operation.

// File: rtl/aic_pkg.sv
package aic_pkg;

    localparam int          BUS_AW        = 16;
    localparam int          BUS_DW        = 32;
    localparam logic [15:0] ADDR_COUNT    = 16'h0004;
    localparam logic [15:0] ADDR_EVENT    = 16'h2004;
    localparam logic [3:0]  REGION_ROUTE  = 4'h3;
    localparam logic [3:0]  REGION_BANK   = 4'h4;
    localparam logic [7:0]  KIND_HW_LINE  = 8'd1;

    typedef struct packed {
        logic [7:0]  die;
        logic [7:0]  kind;
        logic [15:0] line;
    } evt_word_t;

    typedef enum logic [2:0] {
        BK_TRIG_SET  = 3'd0,
        BK_TRIG_CLR  = 3'd1,
        BK_MASK_SET  = 3'd2,
        BK_MASK_CLR  = 3'd3,
        BK_RAW       = 3'd4,
        BK_NONE      = 3'd7
    } bank_e;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_COUNT,
        SEL_EVENT,
        SEL_ROUTE,
        SEL_BANK
    } region_e;

    typedef struct packed {
        region_e    sel;
        bank_e      bank;
        logic [9:0] line;
        logic [4:0] word;
    } acc_dec_t;

    function automatic acc_dec_t decode_addr(input logic [BUS_AW-1:0] a);
        acc_dec_t d;
        d.sel  = SEL_NONE;
        d.bank = BK_NONE;
        d.line = a[11:2];
        d.word = a[6:2];
        if (a == ADDR_COUNT) begin
            d.sel = SEL_COUNT;
        end else if (a == ADDR_EVENT) begin
            d.sel = SEL_EVENT;
        end else if (a[15:12] == REGION_ROUTE && a[1:0] == 2'b00) begin
            d.sel = SEL_ROUTE;
        end else if (a[15:12] == REGION_BANK && a[11:10] == 2'b00 && a[1:0] == 2'b00) begin
            if (a[9:7] <= 3'd4) begin
                d.sel  = SEL_BANK;
                d.bank = bank_e'(a[9:7]);
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/aic_line_state.sv
module aic_line_state
    import aic_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int NUM_CPUS  = 4,
    localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_en,
    input  acc_dec_t                          wr_dec,
    input  logic [BUS_DW-1:0]                 wdata,
    input  logic                              ack_en,
    input  logic [IDX_W-1:0]                  ack_line,
    output logic [NUM_LINES-1:0]              mask_q,
    output logic [NUM_LINES-1:0]              trig_q,
    output logic [NUM_LINES-1:0][NUM_CPUS-1:0] route_q
);

    logic bank_wr;
    logic route_wr;

    assign bank_wr  = wr_en && (wr_dec.sel == SEL_BANK);
    assign route_wr = wr_en && (wr_dec.sel == SEL_ROUTE);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
            trig_q <= '0;
            for (int n = 0; n < NUM_LINES; n++) begin
                route_q[n] <= NUM_CPUS'(1);
            end
        end else begin
            for (int n = 0; n < NUM_LINES; n++) begin
                if (ack_en && int'(ack_line) == n) begin
                    mask_q[n] <= 1'b1;
                end else if (bank_wr && int'(wr_dec.word) == n / 32 && wdata[n % 32]) begin
                    if (wr_dec.bank == BK_MASK_SET) begin
                        mask_q[n] <= 1'b1;
                    end else if (wr_dec.bank == BK_MASK_CLR) begin
                        mask_q[n] <= 1'b0;
                    end
                end
                if (bank_wr && int'(wr_dec.word) == n / 32 && wdata[n % 32]) begin
                    if (wr_dec.bank == BK_TRIG_SET) begin
                        trig_q[n] <= 1'b1;
                    end else if (wr_dec.bank == BK_TRIG_CLR) begin
                        trig_q[n] <= 1'b0;
                    end
                end
                if (route_wr && int'(wr_dec.line) == n) begin
                    route_q[n] <= wdata[NUM_CPUS-1:0];
                end
            end
        end
    end

    // R7
    ack_mask_chk: assert property (@(posedge clk) disable iff (rst)
        ack_en |=> mask_q[$past(ack_line)]);

    // R2
    mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ack_en && !bank_wr) |=> $stable(mask_q));

endmodule

// File: rtl/aic_pick.sv
module aic_pick #(
    parameter int NUM_LINES = 64,
    localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] elig,
    output logic                 found,
    output logic [IDX_W-1:0]     idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int n = NUM_LINES - 1; n >= 0; n--) begin
            if (elig[n]) begin
                found = 1'b1;
                idx   = IDX_W'(n);
            end
        end
    end

    // R4
    lowest_pick_chk: assert property (@(posedge clk) disable iff (rst)
        found |-> (elig[idx] && ((elig & ((NUM_LINES'(1) << idx) - NUM_LINES'(1))) == '0)));

endmodule

// File: rtl/aic_irq_ctrl.sv
module aic_irq_ctrl
    import aic_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int NUM_CPUS  = 4,
    localparam int CPU_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] hw_irq,
    input  logic                 bus_req,
    input  logic                 bus_we,
    input  logic [15:0]          bus_addr,
    input  logic [31:0]          bus_wdata,
    input  logic [CPU_W-1:0]     bus_cpu,
    output logic [31:0]          bus_rdata,
    output logic                 bus_rvalid,
    output logic [NUM_CPUS-1:0]  irq_out
);

    localparam int IDX_W  = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
    localparam int WORDS  = (NUM_LINES + 31) / 32;
    localparam int PAD_W  = WORDS * 32;

    acc_dec_t                           dec;
    logic                               rd_req;
    logic                               evt_rd;
    logic                               ack_en;
    logic                               sel_found;
    logic [IDX_W-1:0]                   sel_idx;
    logic [NUM_LINES-1:0]               line_mask;
    logic [NUM_LINES-1:0]               line_trig;
    logic [NUM_LINES-1:0][NUM_CPUS-1:0] line_route;
    logic [NUM_LINES-1:0]               pending;
    logic [NUM_CPUS-1:0]                cpu_found;
    logic [IDX_W-1:0]                   cpu_idx [NUM_CPUS];
    logic [PAD_W-1:0]                   mask_pad, trig_pad, raw_pad;
    evt_word_t                          evt;
    logic [31:0]                        rd_d;
    logic                               rd_evt_q;

    assign dec     = decode_addr(bus_addr);
    assign rd_req  = bus_req && !bus_we;
    assign evt_rd  = rd_req && (dec.sel == SEL_EVENT);
    assign pending = hw_irq | line_trig;

    aic_line_state #(
        .NUM_LINES (NUM_LINES),
        .NUM_CPUS  (NUM_CPUS)
    ) u_state (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (bus_req && bus_we),
        .wr_dec   (dec),
        .wdata    (bus_wdata),
        .ack_en   (ack_en),
        .ack_line (sel_idx),
        .mask_q   (line_mask),
        .trig_q   (line_trig),
        .route_q  (line_route)
    );

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
        logic [NUM_LINES-1:0] elig;
        always_comb begin
            for (int n = 0; n < NUM_LINES; n++) begin
                elig[n] = pending[n] && !line_mask[n] && line_route[n][c];
            end
        end
        aic_pick #(
            .NUM_LINES (NUM_LINES)
        ) u_pick (
            .clk   (clk),
            .rst   (rst),
            .elig  (elig),
            .found (cpu_found[c]),
            .idx   (cpu_idx[c])
        );
        assign irq_out[c] = cpu_found[c];
    end

    always_comb begin
        sel_found = 1'b0;
        sel_idx   = '0;
        for (int c = 0; c < NUM_CPUS; c++) begin
            if (int'(bus_cpu) == c) begin
                sel_found = cpu_found[c];
                sel_idx   = cpu_idx[c];
            end
        end
    end

    assign ack_en = evt_rd && sel_found;

    always_comb begin
        mask_pad = '0;
        trig_pad = '0;
        raw_pad  = '0;
        mask_pad[NUM_LINES-1:0] = line_mask;
        trig_pad[NUM_LINES-1:0] = line_trig;
        raw_pad[NUM_LINES-1:0]  = hw_irq;
    end

    always_comb begin
        evt.die  = 8'd0;
        evt.kind = KIND_HW_LINE;
        evt.line = 16'(sel_idx);
    end

    always_comb begin
        rd_d = '0;
        unique case (dec.sel)
            SEL_COUNT: rd_d = 32'(NUM_LINES);
            SEL_EVENT: if (sel_found) rd_d = evt;
            SEL_ROUTE: begin
                for (int n = 0; n < NUM_LINES; n++) begin
                    if (int'(dec.line) == n) rd_d = 32'(line_route[n]);
                end
            end
            SEL_BANK: begin
                for (int w = 0; w < WORDS; w++) begin
                    if (int'(dec.word) == w) begin
                        case (dec.bank)
                            BK_TRIG_SET, BK_TRIG_CLR: rd_d = trig_pad[w*32 +: 32];
                            BK_MASK_SET, BK_MASK_CLR: rd_d = mask_pad[w*32 +: 32];
                            BK_RAW:                   rd_d = raw_pad[w*32 +: 32];
                            default:                  rd_d = '0;
                        endcase
                    end
                end
            end
            default: rd_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
            rd_evt_q   <= 1'b0;
        end else begin
            bus_rvalid <= rd_req;
            rd_evt_q   <= evt_rd;
            if (rd_req) begin
                bus_rdata <= rd_d;
            end
        end
    end

    // R7
    auto_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rvalid && rd_evt_q && bus_rdata != '0) |-> line_mask[bus_rdata[IDX_W-1:0]]);

    // R6
    empty_evt_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_rd && !sel_found) |=> (bus_rdata == '0 && $stable(line_mask)));

    // R5
    evt_kind_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rvalid && rd_evt_q && bus_rdata != '0) |-> (bus_rdata[31:16] == 16'h0001));

    // R5
    rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> bus_rvalid);

    // R10
    count_word_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && dec.sel == SEL_COUNT) |=> (bus_rdata == 32'(NUM_LINES)));

endmodule

// File: tb/test_aic_irq_ctrl.sv
module test_aic_irq_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NL  = 64;
    localparam int NC  = 4;
    localparam int CW  = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NL-1:0] hw_irq = '0;
    logic          bus_req = 1'b0;
    logic          bus_we = 1'b0;
    logic [15:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [CW-1:0] bus_cpu = '0;
    logic [31:0]   bus_rdata;
    logic          bus_rvalid;
    logic [NC-1:0] irq_out;

    int checks = 0;
    int fails  = 0;

    logic [NL-1:0] m_mask;
    logic [NL-1:0] m_trig;
    logic [NC-1:0] m_route [NL];

    aic_irq_ctrl #(.NUM_LINES(NL), .NUM_CPUS(NC)) i_aic_irq_ctrl (
        .clk        (clk),
        .rst        (rst),
        .hw_irq     (hw_irq),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_cpu    (bus_cpu),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .irq_out    (irq_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    function automatic logic [15:0] bank_addr(input int bank, input int word);
        return 16'h4000 + 16'(bank * 128) + 16'(word * 4);
    endfunction

    function automatic logic [NL-1:0] m_elig(input int c);
        logic [NL-1:0] e;
        for (int n = 0; n < NL; n++) e[n] = (hw_irq[n] | m_trig[n]) & ~m_mask[n] & m_route[n][c];
        return e;
    endfunction

    function automatic logic [31:0] m_event(input int c);
        logic [NL-1:0] e;
        e = m_elig(c);
        for (int n = 0; n < NL; n++) if (e[n]) return {8'd0, 8'd1, 16'(n)};
        return 32'd0;
    endfunction

    function automatic logic [NC-1:0] m_irq();
        logic [NC-1:0] r;
        for (int c = 0; c < NC; c++) r[c] = |m_elig(c);
        return r;
    endfunction

    function automatic logic [31:0] m_bank_read(input int bank, input int word);
        logic [31:0] r;
        for (int b = 0; b < 32; b++) begin
            case (bank)
                0, 1:    r[b] = m_trig[word*32+b];
                2, 3:    r[b] = m_mask[word*32+b];
                default: r[b] = hw_irq[word*32+b];
            endcase
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, input int c, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a; bus_cpu = CW'(c);
        @(negedge clk);
        bus_req = 1'b0;
        d = bus_rdata;
    endtask

    task automatic bank_write(input int bank, input int word, input logic [31:0] d);
        bus_write(bank_addr(bank, word), d);
        for (int b = 0; b < 32; b++) begin
            if (d[b]) begin
                case (bank)
                    0: m_trig[word*32+b] = 1'b1;
                    1: m_trig[word*32+b] = 1'b0;
                    2: m_mask[word*32+b] = 1'b1;
                    3: m_mask[word*32+b] = 1'b0;
                    default: ;
                endcase
            end
        end
    endtask

    task automatic route_write(input int n, input logic [NC-1:0] r);
        bus_write(16'h3000 + 16'(n * 4), 32'(r));
        m_route[n] = r;
    endtask

    task automatic event_check(input string tag, input int c);
        logic [31:0] exp, got;
        exp = m_event(c);
        bus_read(16'h2004, c, got);
        check(tag, got, exp);
        if (exp != 0) m_mask[exp[5:0]] = 1'b1;
    endtask

    task automatic bank_check(input string tag, input int bank, input int word);
        logic [31:0] got;
        bus_read(bank_addr(bank, word), 0, got);
        check(tag, got, m_bank_read(bank, word));
    endtask

    task automatic irq_check(input string tag);
        check(tag, 32'(irq_out), 32'(m_irq()));
    endtask

    initial begin
        logic [31:0] got;
        void'($urandom(32'd20240611));
        m_mask = '1;
        m_trig = '0;
        for (int n = 0; n < NL; n++) m_route[n] = NC'(1);

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 irq_out after reset", 32'(irq_out), 32'd0);
        bus_read(bank_addr(2, 0), 0, got); check("R1 mask word0", got, 32'hffff_ffff);
        bus_read(bank_addr(3, 1), 0, got); check("R1 mask word1", got, 32'hffff_ffff);
        bus_read(bank_addr(0, 0), 0, got); check("R1 trigger word0", got, 32'd0);
        bus_read(16'h3000 + 16'd20, 0, got); check("R1 route line5", got, 32'd1);
        hw_irq = 64'h0000_0001_0000_0010;
        bus_read(16'h2004, 0, got); check("R1 event with all masked", got, 32'd0);
        hw_irq = '0;

        // R10 line count
        bus_read(16'h0004, 1, got); check("R10 count word", got, 32'(NL));
        bus_read(16'h0100, 0, got); check("R10 unmapped reads zero", got, 32'd0);

        // R2 write-1 mask banks, word 4*(n>>5), bit n&31
        bank_write(3, 0, 32'h0000_0401);
        bank_check("R2 clear bits 0,10", 2, 0);
        bank_write(2, 0, 32'h0000_0000);
        bank_check("R2 zero write no effect", 3, 0);
        bank_write(3, 1, 32'h0000_0020);
        bank_check("R2 line 37 in word1 bit5", 2, 1);
        bank_write(2, 0, 32'h0000_0001);
        bank_check("R2 set bit0", 2, 0);

        // R3 trigger bits and OR with hardware
        bank_write(0, 0, 32'h0000_0404);
        bank_check("R3 trigger set", 0, 0);
        @(negedge clk);
        irq_check("R9 trigger on unmasked line 10");
        bank_write(1, 0, 32'h0000_0400);
        bank_check("R3 trigger clear", 1, 0);
        irq_check("R9 irq low after trigger clear");
        hw_irq[10] = 1'b1;
        @(negedge clk);
        irq_check("R3 hw line pending with trigger clear");
        bus_write(bank_addr(4, 0), 32'hffff_ffff);
        bank_check("R3 raw bank ignores writes", 4, 0);
        irq_check("R3 raw bank write no effect on irq");

        // R5 / R7 event encoding and auto-mask
        event_check("R5 event encoding line 10", 0);
        irq_check("R7 irq drops after auto-mask");
        bank_check("R7 mask bit 10 set", 2, 0);
        event_check("R6 nothing pending after ack", 0);
        hw_irq[10] = 1'b0;

        // R4 lowest number wins
        bank_write(3, 0, 32'h0000_0080);
        bank_write(3, 1, 32'h0000_0100);
        hw_irq[40] = 1'b1; hw_irq[7] = 1'b1;
        event_check("R4 lowest first (7)", 0);
        event_check("R4 next (40)", 0);
        event_check("R6 empty returns zero", 0);
        hw_irq = '0;

        // R8 routing
        route_write(7, 4'b0100);
        bus_read(16'h3000 + 16'd28, 0, got); check("R8 route readback", got, 32'h4);
        bank_write(3, 0, 32'h0000_0080);
        hw_irq[7] = 1'b1;
        @(negedge clk);
        irq_check("R8 irq only on cpu2");
        event_check("R8 cpu0 sees nothing", 0);
        event_check("R8 cpu2 gets line 7", 2);
        hw_irq = '0;

        // Same-cycle: event read while a lower line rises
        bank_write(2, 0, 32'hffff_ffff);
        bank_write(2, 1, 32'hffff_ffff);
        route_write(3, 4'b0001);
        route_write(10, 4'b0001);
        bank_write(3, 0, 32'h0000_0408);
        hw_irq[10] = 1'b1;
        @(negedge clk);
        hw_irq[3] = 1'b1;
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = 16'h2004; bus_cpu = '0;
        @(negedge clk);
        bus_req = 1'b0;
        check("R4 collision reports line 3", bus_rdata, 32'h0001_0003);
        m_mask[3] = 1'b1;
        irq_check("R9 irq held by line 10 after collision");
        event_check("R7 collision next read line 10", 0);
        hw_irq = '0;

        // Random mix
        for (int it = 0; it < 600; it++) begin
            int op;
            op = int'($urandom_range(0, 5));
            case (op)
                0: begin
                    hw_irq = {$urandom(), $urandom()} & {$urandom(), $urandom()};
                    @(negedge clk);
                end
                1: bank_write(int'($urandom_range(0, 4)), int'($urandom_range(0, 1)),
                              $urandom() & $urandom() & $urandom());
                2: route_write(int'($urandom_range(0, NL-1)), NC'($urandom()));
                3, 4: event_check("R4 random event", int'($urandom_range(0, NC-1)));
                default: bank_check("R2 random bank read", int'($urandom_range(0, 4)),
                                    int'($urandom_range(0, 1)));
            endcase
            irq_check("R9 random irq_out");
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule